// File: doc/BRIEF.md
# Port Interrupt-on-Change Detector

This block watches a six-pin input port and raises a sticky change flag when any pin that software has armed differs from a stored reference. The reference is not the previous clock sample: it is the pin value captured at the most recent software read or write of the port. Software arms pins through a six-bit enable register. It acknowledges a change by first touching the port, which reloads the reference and ends the mismatch, and then writing 0 to the flag.

The flag drives two requests. A wake request is raised while the device sleeps. An interrupt request is raised when the global interrupt enable is set. Two resets exist. The power-on reset clears everything. The external or brown-out reset clears only the flag and keeps the reference and the enables, so a mismatch that is still present sets the flag again. An oscillator-mode input removes the two pins that crystal oscillators occupy. A wake-unit input removes pin 3 from detection during sleep.

The flag logic is a two-state machine. `FLG_IDLE` means the flag is clear and `FLG_PENDING` means it is set. The transitions are:
- *arm*: IDLE to PENDING, on a qualified mismatch or on a write of 1.
- *hold*: PENDING to PENDING, while a set cause persists.
- *ack*: PENDING to IDLE, on a write of 0 when no set cause is present.
- *drop*: any state to IDLE, on the external reset.

Top module: `ioc_detector`

## Requirements
- R1: After a power-on reset, `en_rdata` is 0, `chg_flag`, `irq` and `wake_req` are 0, and the reference holds 0. Pins that are nonzero at power-up therefore set the flag once they are enabled.
- R2: A write to the enable register stores `en_wdata[5:0]`. With `osc_xtal` = 0, `en_rdata[5:0]` returns the stored bits and `en_rdata[7:6]` reads 0.
- R3: Suppose an enabled pin differs from the reference in a cycle with no port access. Then `chg_flag` is 1 after the next clock edge. A difference on a disabled pin leaves the flag at 0.
- R4: A port read (`port_rd`) or port write (`port_wr`) loads the current pins into the reference at that clock edge. After that edge, unchanged pins cause no flag.
- R5: A pin change in the same cycle as a port access does not set the flag. The access captures the new value.
- R6: A flag write of 0 (`flag_wr` = 1, `flag_wdata` = 0) has no effect while an unacknowledged mismatch exists. It clears the flag after the port has been accessed.
- R7: An external reset (`ext_rst_n` = 0) clears the flag at the next clock edge and leaves the enables and the reference unchanged. If a mismatch remains, the flag is 1 again one edge after the reset is released.
- R8: `irq` equals `chg_flag` AND `gie`, combinationally.
- R9: `wake_req` equals `chg_flag` AND `sleep`, combinationally.
- R10: With `osc_xtal` = 1, enable bits 5 and 4 read as 0 and their pins cannot set the flag.
- R11: While `sleep` = 1 and `wake_unit_en` = 1, pin 3 cannot set the flag. When either input is 0, pin 3 works normally.
- R12: A flag write of 1 sets `chg_flag` at the next edge. A set cause in the same cycle as a write of 0 wins over the clear.
- R13: `port_rdata` returns the pin values in bits 5:0, with bits 7:6 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| ext_rst_n | input | 1 | External or brown-out reset, synchronous, active low |
| pin_in | input | 6 | Synchronized port pin values |
| port_rd | input | 1 | Port read strobe |
| port_wr | input | 1 | Port write strobe |
| port_rdata | output | 8 | Port read data |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 6 | Enable register write data |
| en_rdata | output | 8 | Enable register read data |
| flag_wr | input | 1 | Change flag write strobe |
| flag_wdata | input | 1 | Change flag write value |
| osc_xtal | input | 1 | Crystal-type oscillator mode is active |
| sleep | input | 1 | Device is asleep |
| wake_unit_en | input | 1 | Wake-up unit is enabled |
| gie | input | 1 | Global interrupt enable |
| chg_flag | output | 1 | Sticky change flag |
| irq | output | 1 | Interrupt request |
| wake_req | output | 1 | Wake-from-sleep request |

## Verification
Each internal register fault shows at the ports within one or two clock edges.
- A wrong reference value sets `chg_flag` on the edge after the next enabled pin comparison, even though no pin changed.
- A wrong enable bit appears at once on `en_rdata`. It also shows as a missing or unexpected flag one edge after a pin toggle.
- A flag machine stuck in either state appears at once on `chg_flag`, `irq` and `wake_req`.

The sweeps toggle every pin under every enable pattern, so each register bit is exposed in this way.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
    localparam int IOC_PINS  = 6;
    localparam int IOC_REG_W = 8;
    localparam int IOC_XT_LO = 4;
    localparam int IOC_XT_HI = 5;
    localparam int IOC_WK_PIN = 3;

    typedef enum logic {
        FLG_IDLE    = 1'b0,
        FLG_PENDING = 1'b1
    } flag_state_e;
endpackage

// File: rtl/ioc_enable_reg.sv
module ioc_enable_reg #(
    parameter int PINS   = 6,
    parameter int XT_LO  = 4,
    parameter int XT_HI  = 5,
    parameter int WK_PIN = 3
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            en_wr,
    input  logic [PINS-1:0] en_wdata,
    input  logic            osc_xtal,
    input  logic            sleep,
    input  logic            wake_unit_en,
    output logic [PINS-1:0] en_read,
    output logic [PINS-1:0] en_eff
);
    logic [PINS-1:0] en_q;
    logic            wk_block;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            en_q <= '0;
        else if (en_wr)
            en_q <= en_wdata;
    end

    assign wk_block = sleep & wake_unit_en;

    for (genvar i = 0; i < PINS; i++) begin : g_bit
        if (i >= XT_LO && i <= XT_HI) begin : g_xt
            assign en_read[i] = en_q[i] & ~osc_xtal;
        end else begin : g_plain
            assign en_read[i] = en_q[i];
        end
        if (i == WK_PIN) begin : g_wk
            assign en_eff[i] = en_read[i] & ~wk_block;
        end else begin : g_nowk
            assign en_eff[i] = en_read[i];
        end
    end
endmodule

// File: rtl/ioc_ref_latch.sv
module ioc_ref_latch #(
    parameter int PINS = 6
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            access,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] ref_q
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            ref_q <= '0;
        else if (access)
            ref_q <= pin_in;
    end
endmodule

// File: rtl/ioc_compare.sv
module ioc_compare #(
    parameter int PINS = 6
) (
    input  logic [PINS-1:0] pin_in,
    input  logic [PINS-1:0] ref_q,
    input  logic [PINS-1:0] en_eff,
    input  logic            access,
    output logic            mismatch,
    output logic            hit
);
    logic [PINS-1:0] diff;

    assign diff     = (pin_in ^ ref_q) & en_eff;
    assign mismatch = |diff;
    assign hit      = mismatch & ~access;
endmodule

// File: rtl/ioc_flag_fsm.sv
module ioc_flag_fsm
    import ioc_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic ext_rst_n,
    input  logic hit,
    input  logic flag_wr,
    input  logic flag_wdata,
    output logic chg_flag
);
    flag_state_e state_q, state_d;
    logic        set_req, clr_req;

    assign set_req = hit | (flag_wr & flag_wdata);
    assign clr_req = flag_wr & ~flag_wdata;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            state_q <= FLG_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!ext_rst_n) begin
            state_d = FLG_IDLE;
        end else begin
            unique case (state_q)
                FLG_IDLE:    if (set_req) state_d = FLG_PENDING;
                FLG_PENDING: if (!set_req && clr_req) state_d = FLG_IDLE;
                default:     state_d = FLG_IDLE;
            endcase
        end
    end

    always_comb begin
        chg_flag = (state_q == FLG_PENDING);
    end
endmodule

// File: rtl/ioc_detector.sv
module ioc_detector
    import ioc_pkg::*;
#(
    parameter int PINS   = IOC_PINS,
    parameter int REG_W  = IOC_REG_W,
    parameter int XT_LO  = IOC_XT_LO,
    parameter int XT_HI  = IOC_XT_HI,
    parameter int WK_PIN = IOC_WK_PIN
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             ext_rst_n,
    input  logic [PINS-1:0]  pin_in,
    input  logic             port_rd,
    input  logic             port_wr,
    output logic [REG_W-1:0] port_rdata,
    input  logic             en_wr,
    input  logic [PINS-1:0]  en_wdata,
    output logic [REG_W-1:0] en_rdata,
    input  logic             flag_wr,
    input  logic             flag_wdata,
    input  logic             osc_xtal,
    input  logic             sleep,
    input  logic             wake_unit_en,
    input  logic             gie,
    output logic             chg_flag,
    output logic             irq,
    output logic             wake_req
);
    localparam int PAD_W = REG_W - PINS;

    logic            access;
    logic [PINS-1:0] en_read, en_eff, ref_q;
    logic            mismatch, hit;

    assign access = port_rd | port_wr;

    ioc_enable_reg #(.PINS(PINS), .XT_LO(XT_LO), .XT_HI(XT_HI), .WK_PIN(WK_PIN)) u_en (
        .clk(clk), .por_n(por_n), .en_wr(en_wr), .en_wdata(en_wdata),
        .osc_xtal(osc_xtal), .sleep(sleep), .wake_unit_en(wake_unit_en),
        .en_read(en_read), .en_eff(en_eff)
    );

    ioc_ref_latch #(.PINS(PINS)) u_ref (
        .clk(clk), .por_n(por_n), .access(access), .pin_in(pin_in), .ref_q(ref_q)
    );

    ioc_compare #(.PINS(PINS)) u_cmp (
        .pin_in(pin_in), .ref_q(ref_q), .en_eff(en_eff), .access(access),
        .mismatch(mismatch), .hit(hit)
    );

    ioc_flag_fsm u_fsm (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .hit(hit),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata), .chg_flag(chg_flag)
    );

    assign port_rdata = {{PAD_W{1'b0}}, pin_in};
    assign en_rdata   = {{PAD_W{1'b0}}, en_read};
    assign irq        = chg_flag & gie;
    assign wake_req   = chg_flag & sleep;
endmodule

// File: rtl/ioc_detector_chk.sv
module ioc_detector_chk #(
    parameter int PINS = 6
) (
    input logic            clk,
    input logic            por_n,
    input logic            ext_rst_n,
    input logic [PINS-1:0] pin_in,
    input logic [PINS-1:0] ref_q,
    input logic            access,
    input logic            mismatch,
    input logic            flag_wr,
    input logic            flag_wdata,
    input logic            gie,
    input logic            chg_flag,
    input logic            irq
);
    // R3
    set_on_mismatch_chk: assert property (@(posedge clk) disable iff (!por_n)
        (ext_rst_n && mismatch && !access) |=> chg_flag);

    // R4
    ref_reload_chk: assert property (@(posedge clk) disable iff (!por_n)
        access |=> (ref_q == $past(pin_in)));

    // R6
    clear_blocked_chk: assert property (@(posedge clk) disable iff (!por_n)
        (chg_flag && ext_rst_n && mismatch && !access) |=> chg_flag);

    // R7
    ext_reset_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        !ext_rst_n |=> !chg_flag);

    // R12
    flag_cause_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(chg_flag) |-> ($past(mismatch && !access) || $past(flag_wr && flag_wdata)));

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
        irq |-> (chg_flag && gie));
endmodule

bind ioc_detector ioc_detector_chk #(.PINS(PINS)) u_chk (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .pin_in(pin_in),
    .ref_q(ref_q), .access(access), .mismatch(mismatch), .flag_wr(flag_wr),
    .flag_wdata(flag_wdata), .gie(gie), .chg_flag(chg_flag), .irq(irq)
);

// File: tb/ioc_detector_bench.sv
module ioc_detector_bench;
    logic       clk = 1'b0;
    logic       por_n = 1'b0, ext_rst_n = 1'b1;
    logic [5:0] pin_in = '0, en_wdata = '0;
    logic       port_rd = 0, port_wr = 0, en_wr = 0, flag_wr = 0, flag_wdata = 0;
    logic       osc_xtal = 0, sleep = 0, wake_unit_en = 0, gie = 0;
    logic [7:0] port_rdata, en_rdata;
    logic       chg_flag, irq, wake_req;
    int         n_chk = 0, n_fail = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    ioc_detector u_ioc_detector (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .pin_in(pin_in),
        .port_rd(port_rd), .port_wr(port_wr), .port_rdata(port_rdata),
        .en_wr(en_wr), .en_wdata(en_wdata), .en_rdata(en_rdata),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata), .osc_xtal(osc_xtal),
        .sleep(sleep), .wake_unit_en(wake_unit_en), .gie(gie),
        .chg_flag(chg_flag), .irq(irq), .wake_req(wake_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic touch(input logic wr);
        port_rd = ~wr; port_wr = wr; tick(); port_rd = 0; port_wr = 0;
    endtask

    task automatic set_en(input logic [5:0] v);
        en_wr = 1; en_wdata = v; tick(); en_wr = 0;
    endtask

    task automatic flag_write(input logic v);
        flag_wr = 1; flag_wdata = v; tick(); flag_wr = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [5:0] base;
        pin_in = 6'h15;
        repeat (3) tick();
        // R1 reset state
        chk("R1 en_rdata", en_rdata, 8'h00);
        chk("R1 flag", {7'b0, chg_flag}, 8'h00);
        chk("R1 irq/wake", {6'b0, irq, wake_req}, 8'h00);
        por_n = 1; tick();
        chk("R1 flag after release", {7'b0, chg_flag}, 8'h00);
        set_en(6'h3F); tick();
        chk("R1 reference cleared to 0", {7'b0, chg_flag}, 8'h01);
        // R13 port read data
        chk("R13 port_rdata", port_rdata, 8'h15);
        touch(0); flag_write(0);
        chk("R6 clear after access", {7'b0, chg_flag}, 8'h00);

        // R2 enable readback sweep
        for (int e = 0; e < 64; e++) begin
            set_en(e[5:0]);
            chk("R2 en_rdata", en_rdata, {2'b00, e[5:0]});
        end

        // R3 sweep: every enable pattern, every pin toggled
        for (int e = 0; e < 64; e++) begin
            base = 6'((e * 37) & 63);
            pin_in = base;
            en_wr = 1; en_wdata = e[5:0]; port_rd = 1; tick();
            en_wr = 0; port_rd = 0;
            flag_write(0);
            for (int b = 0; b < 6; b++) begin
                pin_in = base ^ (6'd1 << b); tick();
                chk("R3 toggle", {7'b0, chg_flag}, {7'b0, e[b]});
                pin_in = base; flag_write(0);
                chk("R3 clear when pins restored", {7'b0, chg_flag}, 8'h00);
            end
        end

        // R4 reload by read and write
        set_en(6'h3F); pin_in = 6'h2A; touch(1); flag_write(0); tick();
        chk("R4 write reload", {7'b0, chg_flag}, 8'h00);
        pin_in = 6'h0F; touch(0); flag_write(0); tick();
        chk("R4 read reload", {7'b0, chg_flag}, 8'h00);

        // R5 change in the access cycle
        pin_in = 6'h30; port_rd = 1; tick(); port_rd = 0;
        chk("R5 same-cycle change", {7'b0, chg_flag}, 8'h00);
        tick();
        chk("R5 after", {7'b0, chg_flag}, 8'h00);

        // R6 clear blocked while mismatch persists
        pin_in = 6'h31; tick();
        chk("R6 set", {7'b0, chg_flag}, 8'h01);
        flag_write(0);
        chk("R6 clear blocked", {7'b0, chg_flag}, 8'h01);
        touch(0);
        chk("R6 access keeps flag", {7'b0, chg_flag}, 8'h01);
        flag_write(0);
        chk("R6 clear after access", {7'b0, chg_flag}, 8'h00);

        // R12 set by write; set cause beats clear
        flag_write(1);
        chk("R12 write 1", {7'b0, chg_flag}, 8'h01);
        touch(0); flag_write(0);
        pin_in = 6'h11; flag_wr = 1; flag_wdata = 0; tick(); flag_wr = 0;
        chk("R12 set beats clear", {7'b0, chg_flag}, 8'h01);

        // R7 external reset
        ext_rst_n = 0; tick();
        chk("R7 flag cleared", {7'b0, chg_flag}, 8'h00);
        chk("R7 enables kept", en_rdata, 8'h3F);
        ext_rst_n = 1; tick();
        chk("R7 flag re-set", {7'b0, chg_flag}, 8'h01);
        touch(0); flag_write(0);
        ext_rst_n = 0; tick(); ext_rst_n = 1; tick(); tick();
        chk("R7 reference kept", {7'b0, chg_flag}, 8'h00);

        // R8 / R9 gating sweep
        for (int f = 0; f < 2; f++) begin
            if (f == 1) flag_write(1); else begin touch(0); flag_write(0); end
            for (int g = 0; g < 4; g++) begin
                gie = g[0]; sleep = g[1]; #1;
                chk("R8 irq", {7'b0, irq}, {7'b0, f[0] & g[0]});
                chk("R9 wake_req", {7'b0, wake_req}, {7'b0, f[0] & g[1]});
            end
        end
        gie = 0; sleep = 0;

        // R10 crystal mode
        touch(0); flag_write(0);
        osc_xtal = 1; #1;
        chk("R10 readback", en_rdata, 8'h0F);
        pin_in = pin_in ^ 6'h30; tick();
        chk("R10 pins 5:4 ignored", {7'b0, chg_flag}, 8'h00);
        pin_in = pin_in ^ 6'h08; tick();
        chk("R10 pin 3 active", {7'b0, chg_flag}, 8'h01);
        osc_xtal = 0; #1;
        chk("R10 readback off", en_rdata, 8'h3F);

        // R11 wake unit masks pin 3 in sleep
        touch(0); flag_write(0);
        sleep = 1; wake_unit_en = 1;
        pin_in = pin_in ^ 6'h08; tick();
        chk("R11 pin 3 ignored", {7'b0, chg_flag}, 8'h00);
        wake_unit_en = 0; tick();
        chk("R11 pin 3 active", {7'b0, chg_flag}, 8'h01);
        sleep = 0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule